// File: doc/BRIEF.md
# End-of-Discharge Voltage Threshold Detector

The block watches a battery cell's voltage and raises two end-of-discharge flags as the cell runs down. An external converter supplies an 8-bit voltage code together with a one-cycle valid strobe, roughly once per second. The code scale is 1.2 V full range, so volts = 1.2 × code / 256. On each strobe the block stores the code in a voltage register, which it presents at its output, and it evaluates both flags from that code.

A single programmable threshold register sets the first, warning, trip point. The second, final, trip point is derived from it and sits about 25 mV lower. This offset is five codes, or about 23.4 mV, and the subtraction saturates at code zero. After reset the threshold holds A2h, which is about 0.76 V. The final trip point then lands at 9Dh, which is about 0.735 V. Host software or a fuse loader writes the threshold through a simple write-enable port. Any later strobe uses the new value.

Top module: `eod_detect`

## Requirements
- R1: While reset is held and after its release, the voltage register reads 00h, both flags read 0, and the threshold register holds A2h.
- R2: The voltage register takes the sample code at the rising clock edge where the valid strobe is 1. It keeps its value at every edge where the strobe is 0.
- R3: At a strobed edge the warning flag becomes 1 when the sample code is less than or equal to the threshold register, and becomes 0 otherwise.
- R4: At a strobed edge the final flag becomes 1 when the sample code is less than or equal to the threshold minus 5, and becomes 0 otherwise. With the default threshold A2h, the final trip code is 9Dh.
- R5: When the threshold is below 5, the final trip code is 00h. A sample of 00h then sets the final flag, and a sample of 01h clears it.
- R6: Both flags keep their value at edges without a strobe, including when the threshold is rewritten.
- R7: A threshold write loads the register at the edge where the write enable is 1. A sample strobed at that same edge is compared against the previous threshold, and samples at later edges use the new one.
- R8: The final flag is never 1 while the warning flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new voltage sample |
| smp_code | input | 8 | Voltage sample code, volts = 1.2 × code / 256 |
| thr_wr_en | input | 1 | Threshold register write enable |
| thr_wr_data | input | 8 | New threshold code |
| volt_reg | output | 8 | Latched voltage code |
| eod_warn | output | 1 | Warning end-of-discharge flag |
| eod_final | output | 1 | Final end-of-discharge flag |

## Verification
The assertions check several properties on every cycle:
- the voltage register loads on a strobe and holds between strobes;
- both flags hold between strobes;
- each flag matches the comparison of the previous sample against the threshold that was live at that time;
- the final flag never stands without the warning flag.

Other behaviours only the bench's scenarios can show. These are the reset default of A2h and its 9Dh final point, seen through exact trip codes. They also include saturation at small thresholds, and the old-value rule when a write and a sample fall on the same edge.

// File: rtl/eod_pkg.sv
package eod_pkg;
    localparam int CODE_W  = 8;
    localparam int NUM_LVL = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t              volt;
        logic [NUM_LVL-1:0] hit;
    } flag_state_t;
endpackage

// File: rtl/eod_thr_reg.sv
module eod_thr_reg
    import eod_pkg::*;
#(
    parameter code_t RST_VAL = 8'hA2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  code_t wr_data,
    output code_t thr
);
    code_t thr_d, thr_q;

    always_comb begin
        thr_d = thr_q;
        if (wr_en) begin
            thr_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= RST_VAL;
        end else begin
            thr_q <= thr_d;
        end
    end

    assign thr = thr_q;
endmodule

// File: rtl/eod_final_thr.sv
module eod_final_thr
    import eod_pkg::*;
#(
    parameter int OFFSET = 5
) (
    input  code_t base,
    output code_t lowered
);
    localparam code_t OFS_C = code_t'(OFFSET);

    generate
        if (OFFSET == 0) begin : g_pass
            assign lowered = base;
        end else begin : g_sat_sub
            always_comb begin
                if (base >= OFS_C) begin
                    lowered = base - OFS_C;
                end else begin
                    lowered = '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/eod_flag_unit.sv
module eod_flag_unit
    import eod_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           valid,
    input  code_t                          sample,
    input  logic [NUM_LVL-1:0][CODE_W-1:0] lvl,
    output code_t                          volt,
    output logic [NUM_LVL-1:0]             hit
);
    flag_state_t st_d, st_q;
    logic [NUM_LVL-1:0] cmp_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LVL; gi++) begin : g_cmp
            assign cmp_hit[gi] = (sample <= lvl[gi]);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.volt = sample;
            st_d.hit  = cmp_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign volt = st_q.volt;
    assign hit  = st_q.hit;
endmodule

// File: rtl/eod_detect.sv
module eod_detect
    import eod_pkg::*;
#(
    parameter code_t THR_RESET  = 8'hA2,
    parameter int    FINAL_OFS  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [CODE_W-1:0]   smp_code,
    input  logic                thr_wr_en,
    input  logic [CODE_W-1:0]   thr_wr_data,
    output logic [CODE_W-1:0]   volt_reg,
    output logic                eod_warn,
    output logic                eod_final
);
    code_t thr_q;
    code_t fin_thr;
    logic [NUM_LVL-1:0][CODE_W-1:0] lvl;
    logic [NUM_LVL-1:0] hit;

    eod_thr_reg #(.RST_VAL(THR_RESET)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (thr_wr_en),
        .wr_data (thr_wr_data),
        .thr     (thr_q)
    );

    eod_final_thr #(.OFFSET(FINAL_OFS)) u_ofs (
        .base    (thr_q),
        .lowered (fin_thr)
    );

    assign lvl[0] = thr_q;
    assign lvl[1] = fin_thr;

    eod_flag_unit u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (smp_valid),
        .sample (smp_code),
        .lvl    (lvl),
        .volt   (volt_reg),
        .hit    (hit)
    );

    assign eod_warn  = hit[0];
    assign eod_final = hit[1];
endmodule

// File: rtl/eod_detect_chk.sv
module eod_detect_chk
    import eod_pkg::*;
#(
    parameter int FINAL_OFS = 5
) (
    input logic  clk,
    input logic  rst_n,
    input logic  smp_valid,
    input code_t smp_code,
    input code_t thr_q,
    input code_t volt_reg,
    input logic  eod_warn,
    input logic  eod_final
);
    // Independent form of the final trip point: compare sample+offset to threshold.
    logic [CODE_W:0] code_plus;
    logic            fin_expect;
    assign code_plus  = {1'b0, smp_code} + (CODE_W+1)'(FINAL_OFS);
    assign fin_expect = (smp_code == '0) || (code_plus <= {1'b0, thr_q});

    assert_volt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> volt_reg == $past(smp_code));

    assert_volt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(volt_reg));

    assert_warn_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> eod_warn == ($past(smp_code) <= $past(thr_q)));

    assert_final_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> eod_final == $past(fin_expect));

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(eod_warn) && $stable(eod_final)));

    assert_final_under_warn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eod_final |-> eod_warn);
endmodule

bind eod_detect eod_detect_chk #(.FINAL_OFS(FINAL_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .thr_q     (thr_q),
    .volt_reg  (volt_reg),
    .eod_warn  (eod_warn),
    .eod_final (eod_final)
);

// File: tb/sim_eod_detect.sv
module sim_eod_detect;
    localparam int CLK_P = 10;

    typedef struct {
        logic [7:0] code;
        logic       warn;
        logic       fin;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_code = '0;
    logic       thr_wr_en = 1'b0;
    logic [7:0] thr_wr_data = '0;
    logic [7:0] volt_reg;
    logic       eod_warn;
    logic       eod_final;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model_thr = 8'hA2;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    eod_detect u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_code    (smp_code),
        .thr_wr_en   (thr_wr_en),
        .thr_wr_data (thr_wr_data),
        .volt_reg    (volt_reg),
        .eod_warn    (eod_warn),
        .eod_final   (eod_final)
    );

    function automatic logic [7:0] fin_of(input logic [7:0] t);
        return (t >= 8'd5) ? t - 8'd5 : 8'd0;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t mk(input logic [7:0] c, input string tag);
        exp_t e;
        e.code = c;
        e.warn = (c <= model_thr);
        e.fin  = (c <= fin_of(model_thr));
        e.tag  = tag;
        return e;
    endfunction

    task automatic do_sample(input logic [7:0] c, input string tag);
        @(negedge clk);
        smp_code  = c;
        smp_valid = 1'b1;
        sb.push_back(mk(c, tag));
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] t);
        @(negedge clk);
        thr_wr_en   = 1'b1;
        thr_wr_data = t;
        @(negedge clk);
        thr_wr_en = 1'b0;
        model_thr = t;
    endtask

    // write and sample on the same edge: expectation uses the old threshold
    task automatic do_both(input logic [7:0] t, input logic [7:0] c, input string tag);
        @(negedge clk);
        thr_wr_en   = 1'b1;
        thr_wr_data = t;
        smp_code    = c;
        smp_valid   = 1'b1;
        sb.push_back(mk(c, tag));
        @(negedge clk);
        thr_wr_en = 1'b0;
        smp_valid = 1'b0;
        model_thr = t;
    endtask

    // monitor: compares each strobed result shortly after its edge
    initial begin
        forever begin
            @(posedge clk);
            if (smp_valid && rst_n) begin
                #1;
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R2 unexpected sample actual=%h expected=none", volt_reg);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " volt R2"}, volt_reg, e.code);
                    check({e.tag, " warn R3"}, {7'd0, eod_warn}, {7'd0, e.warn});
                    check({e.tag, " final R4"}, {7'd0, eod_final}, {7'd0, e.fin});
                end
            end
        end
    end

    task automatic hold_check(input string tag, input logic [7:0] v, input logic w, input logic f);
        check({tag, " volt hold R2"}, volt_reg, v);
        check({tag, " warn hold R6"}, {7'd0, eod_warn}, {7'd0, w});
        check({tag, " final hold R6"}, {7'd0, eod_final}, {7'd0, f});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        hold_check("R1 in reset", 8'h00, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        hold_check("R1 after reset", 8'h00, 1'b0, 1'b0);

        // default threshold A2h, final 9Dh
        do_sample(8'hA2, "R1 default warn edge");
        do_sample(8'hA3, "R3 above warn");
        do_sample(8'h9E, "R4 just above final");
        do_sample(8'h9D, "R4 default final edge");
        do_sample(8'h00, "R3 zero code");
        do_sample(8'hFF, "R3 full code");
        repeat (4) @(negedge clk);
        hold_check("R6 idle", 8'hFF, 1'b0, 1'b0);

        do_both(8'h40, 8'h50, "R7 same edge old thr");
        do_sample(8'h50, "R7 new thr above");
        do_sample(8'h40, "R7 new thr warn edge");
        do_sample(8'h3B, "R4 new thr final edge");
        do_write(8'hFF);
        repeat (3) @(negedge clk);
        hold_check("R6 after write", 8'h3B, 1'b1, 1'b1);
        do_write(8'h00);
        repeat (2) @(negedge clk);
        hold_check("R6 after low write", 8'h3B, 1'b1, 1'b1);

        do_write(8'h03);
        do_sample(8'h01, "R5 thr 03 code 01");
        do_sample(8'h00, "R5 thr 03 code 00");
        do_write(8'h05);
        do_sample(8'h00, "R5 thr 05 code 00");
        do_sample(8'h01, "R5 thr 05 code 01");
        do_write(8'h00);
        do_sample(8'h00, "R5 thr 00 code 00");
        do_sample(8'h01, "R5 thr 00 code 01");
        do_write(8'h06);
        do_sample(8'h01, "R4 thr 06 code 01");
        do_sample(8'h02, "R4 thr 06 code 02");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 missing results actual=%0d expected=0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule